// File: doc/BRIEF.md
# Flash Line Prefetch Buffer

This block sits between a system bus read port and a slow flash memory interface that always returns whole 256-bit lines. It keeps two line buffers. A bus read whose line is already held is answered in the same cycle it is presented, with the addressed 64-bit word picked out of the buffered line. A read whose line is not held makes the block fetch that line from flash, install it, and then answer from the buffer.

After a miss the block can fetch the following sequential line into the other buffer, ahead of any request for it. Whether this happens depends on two settings. A two-bit mode limits prefetch to instruction fetches, to data reads, or to any read, or turns it off. A per-master enable mask allows or blocks prefetch for each requesting master. Replacement between the two buffers is least recently used. A write aimed at flash empties both buffers, so no stale line survives a program operation.

The flash side takes one read request at a time. A request is a one-cycle enable with a line address and a fixed size code. The line comes back some cycles later with a one-cycle done strobe.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset no line is buffered, `fl_rd_en` is low and `bus_ready` is low while `bus_req` is low.
- R2: A read (`bus_req`=1, `bus_write`=0) whose line address `bus_addr[ADDR_W-1:5]` matches a valid buffer raises `bus_ready` in that same cycle, and `bus_rdata` carries word `bus_addr[4:3]` of the line. Word 0 is line bits [63:0] and word 3 is bits [255:192].
- R3: A read that misses issues a one-cycle `fl_rd_en` with `fl_line_addr` equal to the requested line address and `fl_size` equal to 5 (log2 of 32 bytes). The read is answered from the buffer with correct data once `fl_done` has returned that line.
- R4: After a missed line has been installed, and when prefetch is permitted for that miss, the block fetches line address + 1 into the other buffer. The prefetch is skipped when the other buffer already holds that line. The two buffers never hold the same line.
- R5: `cfg_pf_mode` encodes 00 = prefetch off, 01 = only when the missing read is an instruction fetch (`bus_instr`=1), 10 = only when it is a data read (`bus_instr`=0), 11 = any read.
- R6: Prefetch also requires `cfg_master_pf[bus_master]` to be 1 for the master whose read missed.
- R7: An empty buffer is filled before a valid one is replaced. When both are valid, the one not used most recently is replaced. Hits and demand fills count as use.
- R8: A buffer that is being filled never reports a hit. A read for a line whose prefetch is in flight waits for that fill and returns its data without a second flash read.
- R9: A write (`bus_req`=1, `bus_write`=1) is acknowledged with `bus_ready` in the same cycle and invalidates both buffers. A fill in flight at that time is discarded when it returns.
- R10: At most one flash read is outstanding. A miss that arrives while a prefetch is in flight waits until that prefetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write to flash (invalidates), 0 = read |
| bus_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| bus_master | input | MID_W (2) | Requesting master number |
| bus_addr | input | ADDR_W (24) | Byte address |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | BUS_W (64) | Read data word |
| cfg_pf_mode | input | 2 | Prefetch trigger mode |
| cfg_master_pf | input | MASTERS (4) | Per-master prefetch enable |
| fl_rd_en | output | 1 | One-cycle flash line read request |
| fl_line_addr | output | ADDR_W-5 (19) | Line address of the request |
| fl_size | output | 3 | Transfer size code, log2 of bytes (5) |
| fl_done | input | 1 | One-cycle strobe: requested line is on `fl_rdata` |
| fl_rdata | input | LINE_W (256) | Returned line |

## Verification
A wrong tag or valid bit shows at the bus on the very next read of the affected line. That read either returns the wrong word with `bus_ready` in the same cycle, or stalls where it should have hit. It also shows at the flash port as an extra or missing `fl_rd_en`. Prefetch policy faults show only at the flash port, as a wrong number of line reads about a latency period after the miss. For this reason the checks count flash reads after every miss, besides checking data and the cycles the read waited. Replacement faults stay hidden until a third distinct line forces an eviction, and the next access to the evicted line then shows them.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEMAND = 2'd1,
        ST_PREF   = 2'd2
    } flp_state_e;

    localparam logic [1:0] PF_OFF   = 2'b00;
    localparam logic [1:0] PF_INSTR = 2'b01;
    localparam logic [1:0] PF_DATA  = 2'b10;
    localparam logic [1:0] PF_ANY   = 2'b11;

endpackage

// File: rtl/flp_policy.sv
module flp_policy #(
    parameter int MASTERS = 4,
    localparam int MID_W  = (MASTERS > 1) ? $clog2(MASTERS) : 1
) (
    input  logic [1:0]         mode,
    input  logic               is_instr,
    input  logic [MID_W-1:0]   master,
    input  logic [MASTERS-1:0] master_en,
    output logic               allow
);
    import flp_pkg::*;

    logic type_ok;

    always_comb begin
        unique case (mode)
            PF_INSTR: type_ok = is_instr;
            PF_DATA:  type_ok = !is_instr;
            PF_ANY:   type_ok = 1'b1;
            default:  type_ok = 1'b0;
        endcase
        allow = type_ok && master_en[master];
    end

endmodule

// File: rtl/flp_tag_match.sv
module flp_tag_match #(
    parameter int NBUF  = 2,
    parameter int LA_W  = 19,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NBUF-1:0]           valid,
    input  logic [NBUF-1:0][LA_W-1:0] tags,
    input  logic [LA_W-1:0]           lookup,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);

    logic [NBUF-1:0] match;

    for (genvar b = 0; b < NBUF; b++) begin : g_cmp
        assign match[b] = valid[b] && (tags[b] == lookup);
    end

    always_comb begin
        hit_idx = '0;
        for (int b = 0; b < NBUF; b++) begin
            if (match[b]) hit_idx = IDX_W'(b);
        end
        hit = |match;
    end

    // Two valid buffers never carry the same line (R4)
    assert_unique_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/flp_line_store.sv
module flp_line_store #(
    parameter int NBUF   = 2,
    parameter int LINE_W = 256,
    parameter int BUS_W  = 64,
    localparam int WORDS  = LINE_W / BUS_W,
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IDX_W  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [BUS_W-1:0]  rd_data
);

    logic [NBUF-1:0][LINE_W-1:0] lines_d, lines_q;

    always_comb begin
        lines_d = lines_q;
        if (wr_en) lines_d[wr_idx] = wr_line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

    assign rd_data = lines_q[rd_idx][rd_word*BUS_W +: BUS_W];

    // An installed line is readable from its buffer next cycle (R2)
    assert_line_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lines_q[$past(wr_idx)] == $past(wr_line)));

endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch #(
    parameter int ADDR_W  = 24,
    parameter int LINE_W  = 256,
    parameter int BUS_W   = 64,
    parameter int MASTERS = 4,
    localparam int MID_W  = (MASTERS > 1) ? $clog2(MASTERS) : 1,
    localparam int OFS_W  = $clog2(LINE_W / 8),
    localparam int LA_W   = ADDR_W - OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_write,
    input  logic               bus_instr,
    input  logic [MID_W-1:0]   bus_master,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_ready,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [1:0]         cfg_pf_mode,
    input  logic [MASTERS-1:0] cfg_master_pf,
    output logic               fl_rd_en,
    output logic [LA_W-1:0]    fl_line_addr,
    output logic [2:0]         fl_size,
    input  logic               fl_done,
    input  logic [LINE_W-1:0]  fl_rdata
);
    import flp_pkg::*;

    localparam int NBUF   = 2;
    localparam int WORDS  = LINE_W / BUS_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BYTE_W = OFS_W - WSEL_W;

    typedef struct packed {
        flp_state_e                  state;
        logic [NBUF-1:0]             valid;
        logic [NBUF-1:0][LA_W-1:0]   tags;
        logic                        lru;
        logic                        fill_idx;
        logic                        pf_pend;
        logic [LA_W-1:0]             pf_line;
        logic                        discard;
        logic                        rd_en;
        logic [LA_W-1:0]             rd_addr;
    } flp_regs_t;

    flp_regs_t r_d, r_q;

    logic [LA_W-1:0]   req_line;
    logic [WSEL_W-1:0] req_word;
    logic              hit, hit_idx;
    logic              pf_allow;
    logic              rd_hit, rd_miss, wr_req;
    logic              other_idx, next_held;
    logic              victim;
    logic              store_we;
    logic              unused_byte_bits;

    assign req_line         = bus_addr[ADDR_W-1:OFS_W];
    assign req_word         = bus_addr[OFS_W-1:BYTE_W];
    assign unused_byte_bits = ^bus_addr[BYTE_W-1:0];

    flp_tag_match #(.NBUF(NBUF), .LA_W(LA_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (r_q.valid),
        .tags    (r_q.tags),
        .lookup  (req_line),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    flp_policy #(.MASTERS(MASTERS)) u_policy (
        .mode      (cfg_pf_mode),
        .is_instr  (bus_instr),
        .master    (bus_master),
        .master_en (cfg_master_pf),
        .allow     (pf_allow)
    );

    flp_line_store #(.NBUF(NBUF), .LINE_W(LINE_W), .BUS_W(BUS_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_we),
        .wr_idx  (r_q.fill_idx),
        .wr_line (fl_rdata),
        .rd_idx  (hit_idx),
        .rd_word (req_word),
        .rd_data (bus_rdata)
    );

    assign wr_req    = bus_req && bus_write;
    assign rd_hit    = bus_req && !bus_write && hit;
    assign rd_miss   = bus_req && !bus_write && !hit;
    assign bus_ready = wr_req || rd_hit;

    assign other_idx = ~r_q.fill_idx;
    assign next_held = r_q.valid[other_idx] && (r_q.tags[other_idx] == r_q.pf_line);

    always_comb begin
        r_d      = r_q;
        r_d.rd_en = 1'b0;
        store_we = 1'b0;

        if (!r_q.valid[0])      victim = 1'b0;
        else if (!r_q.valid[1]) victim = 1'b1;
        else                    victim = r_q.lru;

        if (rd_hit) r_d.lru = ~hit_idx;

        unique case (r_q.state)
            ST_IDLE: begin
                if (rd_miss) begin
                    r_d.valid[victim] = 1'b0;
                    r_d.tags[victim]  = req_line;
                    r_d.fill_idx      = victim;
                    r_d.pf_pend       = pf_allow;
                    r_d.pf_line       = req_line + LA_W'(1);
                    r_d.discard       = 1'b0;
                    r_d.rd_en         = 1'b1;
                    r_d.rd_addr       = req_line;
                    r_d.state         = ST_DEMAND;
                end
            end
            ST_DEMAND: begin
                if (fl_done) begin
                    r_d.state = ST_IDLE;
                    if (!r_q.discard) begin
                        store_we                = 1'b1;
                        r_d.valid[r_q.fill_idx] = 1'b1;
                        r_d.lru                 = other_idx;
                        if (r_q.pf_pend && !next_held) begin
                            r_d.valid[other_idx] = 1'b0;
                            r_d.tags[other_idx]  = r_q.pf_line;
                            r_d.fill_idx         = other_idx;
                            r_d.rd_en            = 1'b1;
                            r_d.rd_addr          = r_q.pf_line;
                            r_d.state            = ST_PREF;
                        end
                    end
                end
            end
            ST_PREF: begin
                if (fl_done) begin
                    r_d.state = ST_IDLE;
                    if (!r_q.discard) begin
                        store_we                = 1'b1;
                        r_d.valid[r_q.fill_idx] = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (wr_req) begin
            r_d.valid = '0;
            if (r_d.state != ST_IDLE) r_d.discard = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign fl_rd_en     = r_q.rd_en;
    assign fl_line_addr = r_q.rd_addr;
    assign fl_size      = 3'(OFS_W);

    // A flash read is only issued as the block enters a wait state (R10)
    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_en |-> (r_q.state != ST_IDLE));

    // The buffer under fill never answers a lookup (R8)
    assert_fill_not_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && r_q.state != ST_IDLE) |-> (hit_idx != r_q.fill_idx));

    // A write leaves no valid buffer behind (R9)
    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_write) |=> (r_q.valid == '0));

    // A miss in idle always starts a flash read (R3)
    assert_miss_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && bus_req && !bus_write && !bus_ready) |=> fl_rd_en);

endmodule

// File: tb/flash_line_prefetch_test.sv
module flash_line_prefetch_test;

    localparam int ADDR_W = 24;
    localparam int LINE_W = 256;
    localparam int BUS_W  = 64;
    localparam int LA_W   = 19;
    localparam int LAT    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_write = 1'b0, bus_instr = 1'b0;
    logic [1:0]        bus_master = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_ready;
    logic [BUS_W-1:0]  bus_rdata;
    logic [1:0]        cfg_pf_mode = 2'b11;
    logic [3:0]        cfg_master_pf = 4'b1111;
    logic              fl_rd_en;
    logic [LA_W-1:0]   fl_line_addr;
    logic [2:0]        fl_size;
    logic              fl_done = 1'b0;
    logic [LINE_W-1:0] fl_rdata = '0;

    int vectors = 0, fails = 0;
    int nreads = 0, overlap = 0, cnt = 0;
    int last_line = -1;
    logic [LA_W-1:0] pend_addr = '0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_line_prefetch uut (.*);

    function automatic logic [BUS_W-1:0] word_of(int line, int w);
        return {32'(line), 16'hBEEF, 16'(w)};
    endfunction

    function automatic logic [LINE_W-1:0] line_of(int line);
        logic [LINE_W-1:0] v;
        for (int w = 0; w < 4; w++) v[w*64 +: 64] = word_of(line, w);
        return v;
    endfunction

    function automatic logic [ADDR_W-1:0] addr_of(int line, int w);
        return ADDR_W'((line << 5) | (w << 3));
    endfunction

    // flash model: fixed latency, counts requests, flags overlap
    always @(posedge clk) begin
        fl_done <= 1'b0;
        if (rst_n) begin
            if (fl_rd_en) begin
                if (cnt != 0) overlap <= overlap + 1;
                cnt       <= LAT;
                pend_addr <= fl_line_addr;
                nreads    <= nreads + 1;
                last_line <= int'(fl_line_addr);
            end else if (cnt != 0) begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    fl_done  <= 1'b1;
                    fl_rdata <= line_of(int'(pend_addr));
                end
            end
        end
    end

    task automatic check(bit ok, string req, longint act, longint expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
    endtask

    task automatic do_read(int line, int w, bit instr, int master, output int waits);
        logic [BUS_W-1:0] d;
        @(negedge clk);
        bus_req = 1; bus_write = 0; bus_instr = instr;
        bus_master = 2'(master); bus_addr = addr_of(line, w);
        waits = 0;
        #1;
        while (!bus_ready && waits < 300) begin
            @(negedge clk); #1;
            waits++;
        end
        d = bus_rdata;
        check(d == word_of(line, w), "R2/R3 read data", d, word_of(line, w));
        @(negedge clk);
        bus_req = 0;
    endtask

    task automatic do_write();
        @(negedge clk);
        bus_req = 1; bus_write = 1; bus_addr = '0;
        #1;
        check(bus_ready == 1'b1, "R9 write ack same cycle", bus_ready, 1);
        @(negedge clk);
        bus_req = 0; bus_write = 0;
    endtask

    task automatic test_reset();
        #1;
        check(bus_ready == 1'b0, "R1 ready low", bus_ready, 0);
        check(fl_rd_en == 1'b0, "R1 no flash read", fl_rd_en, 0);
        check(nreads == 0, "R1 flash idle", nreads, 0);
    endtask

    task automatic test_miss_prefetch();
        int wt, b;
        b = nreads;
        do_read(10, 2, 0, 0, wt);
        check(wt > 0, "R3 miss waits", wt, 1);
        check(fl_size == 3'd5, "R3 size code", fl_size, 5);
        settle();
        check(nreads - b == 2, "R4 demand plus next line", nreads - b, 2);
        check(last_line == 11, "R4 prefetch address", last_line, 11);
        b = nreads;
        do_read(11, 1, 0, 0, wt);
        check(wt == 0, "R2 prefetched line hits", wt, 0);
        do_read(10, 3, 0, 0, wt);
        check(wt == 0, "R2 demand line hits", wt, 0);
        check(nreads == b, "R2 hits need no flash", nreads - b, 0);
    endtask

    task automatic test_words();
        int wt;
        for (int w = 0; w < 4; w++) begin
            do_read(11, w, 1, 1, wt);
            check(wt == 0, "R2 word select hit", wt, 0);
        end
    endtask

    task automatic mode_case(logic [1:0] m, bit instr, int line, int expn);
        int wt, b;
        cfg_pf_mode = m;
        b = nreads;
        do_read(line, 0, instr, 0, wt);
        settle();
        check(nreads - b == expn, "R5 mode filter", nreads - b, expn);
    endtask

    task automatic test_modes();
        mode_case(2'b01, 0, 40, 1);
        mode_case(2'b01, 1, 60, 2);
        mode_case(2'b10, 0, 80, 2);
        mode_case(2'b10, 1, 100, 1);
        mode_case(2'b00, 1, 120, 1);
        cfg_pf_mode = 2'b11;
    endtask

    task automatic test_masters();
        int wt, b;
        cfg_master_pf = 4'b1011;
        b = nreads;
        do_read(140, 0, 0, 2, wt);
        settle();
        check(nreads - b == 1, "R6 master 2 blocked", nreads - b, 1);
        b = nreads;
        do_read(160, 0, 0, 3, wt);
        settle();
        check(nreads - b == 2, "R6 master 3 allowed", nreads - b, 2);
        cfg_master_pf = 4'b1111;
    endtask

    task automatic test_skip();
        int wt, b;
        do_write();
        cfg_pf_mode = 2'b00;
        do_read(201, 0, 0, 0, wt);
        settle();
        cfg_pf_mode = 2'b11;
        b = nreads;
        do_read(200, 0, 0, 0, wt);
        settle();
        check(nreads - b == 1, "R4 skip held next line", nreads - b, 1);
        do_read(201, 2, 0, 0, wt);
        check(wt == 0, "R4 next line still hits", wt, 0);
    endtask

    task automatic test_lru();
        int wt, b;
        do_write();
        cfg_pf_mode = 2'b00;
        do_read(300, 0, 0, 0, wt);
        do_read(310, 0, 0, 0, wt);
        do_read(300, 1, 0, 0, wt);
        check(wt == 0, "R7 A hit", wt, 0);
        do_read(320, 0, 0, 0, wt);
        check(wt > 0, "R7 C misses", wt, 1);
        b = nreads;
        do_read(300, 2, 0, 0, wt);
        check(wt == 0 && nreads == b, "R7 recent line kept", wt, 0);
        do_read(310, 0, 0, 0, wt);
        check(wt > 0, "R7 stale line evicted", wt, 1);
        cfg_pf_mode = 2'b11;
    endtask

    task automatic test_inflight();
        int wt, b;
        do_write();
        b = nreads;
        do_read(400, 0, 0, 0, wt);
        do_read(401, 3, 0, 0, wt);
        check(wt > 0, "R8 filling buffer not hit", wt, 1);
        settle();
        check(nreads - b == 2, "R10 no duplicate fetch", nreads - b, 2);
    endtask

    task automatic test_write();
        int wt, b;
        cfg_pf_mode = 2'b00;
        do_read(401, 0, 0, 0, wt);
        check(wt == 0, "R9 line held before write", wt, 0);
        do_write();
        b = nreads;
        do_read(401, 0, 0, 0, wt);
        check(wt > 0 && nreads - b == 1, "R9 write invalidated", wt, 1);
        cfg_pf_mode = 2'b11;
        do_read(500, 0, 0, 0, wt);
        do_write();
        settle();
        do_read(501, 0, 0, 0, wt);
        check(wt > 0, "R9 in-flight fill discarded", wt, 1);
        settle();
        check(overlap == 0, "R10 single outstanding read", overlap, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_miss_prefetch();
        test_words();
        test_modes();
        test_masters();
        test_skip();
        test_lru();
        test_inflight();
        test_write();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule